// File: doc/BRIEF.md
# Acknowledge Polling Master Sequencer

This block runs on the master side of a two-wire serial memory bus. After a byte load has been closed with a STOP, the memory starts an internal nonvolatile write and ignores its address until that write ends. The sequencer waits for the end of that write by probing the device. Each probe is a START followed by the slave address byte. The probe ends as soon as the acknowledge bit has been sampled. A probe that is not acknowledged is closed with STOP and another probe follows. A probe that is acknowledged means the write cycle has finished.

After a successful probe the sequencer pulses `done_o`. If the caller has a further read or write command queued, it signals this on `pend_i`, and the sequencer leaves the bus open so that command can follow without a STOP. If nothing is queued, the sequencer closes the bus with STOP. A parameter limits the number of probes. When that limit is reached, the sequencer pulses `timeout_o`, sends STOP and returns to idle.

The sequencer does not drive the bus wires. It hands start, byte and stop requests to a bit-level bus engine through a request/acknowledge handshake, and it never has more than one request outstanding.

Top module: `ackpoll_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `bus_req_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse seen while idle makes `busy_o` 1 and raises `bus_req_o` with `bus_op_o` = 0 (START) in the next cycle.
- R3: A request stays raised with unchanged `bus_op_o` and `bus_data_o` until a cycle in which `bus_ack_i` is 1. A new request is only issued in the cycle its predecessor is acknowledged, or later.
- R4: Once START is acknowledged, the next request has `bus_op_o` = 1 (BYTE) and `bus_data_o` = {address, R/W}, where bit 0 is the R/W bit and bits 7:1 are the 7-bit address. Both values are captured when `start_i` is accepted.
- R5: A probe byte acknowledged with `bus_nack_i` = 1, while fewer than MAX_TRIES probes have been made, is followed by a STOP request (`bus_op_o` = 2) and then by a new START.
- R6: A probe byte acknowledged with `bus_nack_i` = 0 gives a `done_o` pulse of exactly one cycle, in the cycle after that acknowledge.
- R7: After a successful probe with `pend_i` = 0, a STOP request follows and the sequencer then goes idle. With `pend_i` = 1, it goes idle at once and issues no STOP.
- R8: When the MAX_TRIES-th probe is not acknowledged, `timeout_o` pulses for one cycle, a STOP request follows and the sequencer goes idle. `done_o` stays 0 in that case.
- R9: While busy, a `start_i` pulse is ignored, and changes to `dev_addr_i` or `rw_i` do not change the probe byte.
- R10: `busy_o` is 1 from the cycle after `start_i` is accepted until the cycle after the last request of the sequence completes. While `busy_o` is 0, `bus_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling; the byte load has just been closed with STOP |
| dev_addr_i | input | 7 | 7-bit slave address to probe |
| rw_i | input | 1 | R/W bit to place in the probe byte |
| pend_i | input | 1 | A read or write command is queued; keep the bus open on success |
| bus_req_o | output | 1 | Request to the bit-level bus engine |
| bus_op_o | output | 2 | Request kind: 0 START, 1 BYTE, 2 STOP |
| bus_data_o | output | 8 | Byte to send for a BYTE request |
| bus_ack_i | input | 1 | Engine has finished the current request |
| bus_nack_i | input | 1 | With `bus_ack_i` on a BYTE request: slave did not acknowledge |
| busy_o | output | 1 | Polling sequence in progress |
| done_o | output | 1 | One-cycle pulse: write cycle complete |
| timeout_o | output | 1 | One-cycle pulse: probe limit reached without acknowledge |

## Verification
The engine stub answers each request after a delay that rotates through 0, 1 and 2 cycles, so back-to-back reissue on the acknowledge cycle is exercised as well as idle gaps. The probe is tried with these patterns:
- an immediate acknowledge, which separates the plain success path from retries;
- two and three refusals, which check that each retry is closed with STOP;
- a refusal on every probe up to the limit, which separates the timeout path from a late success on the final permitted probe;
- `pend_i` both low and high, which shows whether the closing STOP is skipped;
- a second `start_i` and changed address inputs in the middle of a poll, which shows that the sequence and the probe byte do not move.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_ADDR  = 3'd2,
    ST_RETRY = 3'd3,
    ST_CLOSE = 3'd4
  } poll_state_e;

endpackage

// File: rtl/ackpoll_port.sv
module ackpoll_port
  import ackpoll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  bus_op_e       op_i,
  input  logic [DW-1:0] data_i,
  input  logic          bus_ack_i,
  input  logic          bus_nack_i,
  output logic          bus_req_o,
  output logic [1:0]    bus_op_o,
  output logic [DW-1:0] bus_data_o,
  output logic          fin_o,
  output logic          nack_o
);

  logic          req_q;
  bus_op_e       op_q;
  logic [DW-1:0] data_q;

  // a new request may overwrite the old one in the cycle it is acknowledged
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      op_q   <= OP_START;
      data_q <= '0;
    end else if (issue_i) begin
      req_q  <= 1'b1;
      op_q   <= op_i;
      data_q <= data_i;
    end else if (fin_o) begin
      req_q  <= 1'b0;
    end
  end

  assign bus_req_o  = req_q;
  assign bus_op_o   = op_q;
  assign bus_data_o = data_q;
  assign fin_o      = req_q & bus_ack_i;
  assign nack_o     = bus_nack_i;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_op_o) && $stable(bus_data_o)));

  // R3
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (!bus_req_o || bus_ack_i));

endmodule

// File: rtl/ackpoll_tries.sv
module ackpoll_tries #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // true while the probe now in flight is the final one allowed
  assign last_o = (cnt_q == CW'(MAX_TRIES - 1));

  // R8
  tries_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_TRIES));

endmodule

// File: rtl/ackpoll_ctl.sv
module ackpoll_ctl
  import ackpoll_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rw_i,
  input  logic          pend_i,
  input  logic          fin_i,
  input  logic          nack_i,
  input  logic          last_i,
  output logic          issue_o,
  output bus_op_e       op_o,
  output logic [AW:0]   data_o,
  output logic          clr_o,
  output logic          inc_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o
);

  localparam int DW = AW + 1;

  poll_state_e   state_q, state_d;
  logic [DW-1:0] probe_q;
  logic          done_q, done_d;
  logic          to_q, to_d;
  logic          take;

  assign take = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    issue_o = 1'b0;
    op_o    = OP_START;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    done_d  = 1'b0;
    to_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          clr_o   = 1'b1;
          issue_o = 1'b1;
          op_o    = OP_START;
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (fin_i) begin
          issue_o = 1'b1;
          op_o    = OP_BYTE;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (fin_i) begin
          inc_o = 1'b1;
          if (!nack_i) begin
            done_d = 1'b1;
            if (pend_i) begin
              state_d = ST_IDLE;
            end else begin
              issue_o = 1'b1;
              op_o    = OP_STOP;
              state_d = ST_CLOSE;
            end
          end else if (last_i) begin
            to_d    = 1'b1;
            issue_o = 1'b1;
            op_o    = OP_STOP;
            state_d = ST_CLOSE;
          end else begin
            issue_o = 1'b1;
            op_o    = OP_STOP;
            state_d = ST_RETRY;
          end
        end
      end
      ST_RETRY: begin
        if (fin_i) begin
          issue_o = 1'b1;
          op_o    = OP_START;
          state_d = ST_START;
        end
      end
      ST_CLOSE: begin
        if (fin_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      probe_q <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      to_q    <= to_d;
      if (take) begin
        probe_q <= {addr_i, rw_i};
      end
    end
  end

  assign data_o    = probe_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(fin_i && !nack_i));

  // R8
  timeout_cause_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> $past(fin_i && nack_i));

  // R8
  done_vs_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int AW        = 7,
  parameter int MAX_TRIES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic          rw_i,
  input  logic          pend_i,
  output logic          bus_req_o,
  output logic [1:0]    bus_op_o,
  output logic [AW:0]   bus_data_o,
  input  logic          bus_ack_i,
  input  logic          bus_nack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o
);

  localparam int DW = AW + 1;

  logic          issue;
  bus_op_e       op;
  logic [DW-1:0] data;
  logic          fin, nack, last, clr, inc;

  ackpoll_ctl #(.AW(AW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .addr_i    (dev_addr_i),
    .rw_i      (rw_i),
    .pend_i    (pend_i),
    .fin_i     (fin),
    .nack_i    (nack),
    .last_i    (last),
    .issue_o   (issue),
    .op_o      (op),
    .data_o    (data),
    .clr_o     (clr),
    .inc_o     (inc),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );

  ackpoll_port #(.DW(DW)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue),
    .op_i       (op),
    .data_i     (data),
    .bus_ack_i  (bus_ack_i),
    .bus_nack_i (bus_nack_i),
    .bus_req_o  (bus_req_o),
    .bus_op_o   (bus_op_o),
    .bus_data_o (bus_data_o),
    .fin_o      (fin),
    .nack_o     (nack)
  );

  ackpoll_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .inc_i  (inc),
    .last_o (last)
  );

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !bus_req_o);

endmodule

// File: tb/test_ackpoll_seq.sv
module test_ackpoll_seq;

  localparam int MAXT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [6:0] dev_addr_i = 7'h50;
  logic       rw_i = 1'b0;
  logic       pend_i = 1'b0;
  logic       bus_ack_i = 1'b0;
  logic       bus_nack_i = 1'b0;
  logic       bus_req_o;
  logic [1:0] bus_op_o;
  logic [7:0] bus_data_o;
  logic       busy_o, done_o, timeout_o;

  ackpoll_seq #(.AW(7), .MAX_TRIES(MAXT)) i_ackpoll_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .rw_i(rw_i), .pend_i(pend_i), .bus_req_o(bus_req_o), .bus_op_o(bus_op_o),
    .bus_data_o(bus_data_o), .bus_ack_i(bus_ack_i), .bus_nack_i(bus_nack_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // stimulus hand-off and engine stub state
  bit go = 0;
  int nacks_left = 0;
  int wcnt = 0;
  int lat = 0;
  int cyc = 0;
  bit r2_pending = 0;
  int n_start = 0, n_byte = 0, n_stop = 0, n_done = 0, n_to = 0;

  // reference model
  int  m_state = 0;
  int  m_tries = 0;
  int  m_probe = 0;
  bit  m_req = 0;
  int  m_op = 0;
  int  m_data = 0;
  bit  m_done = 0;
  bit  m_to = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit fin;
    cyc++;
    // compare DUT against the model every cycle
    if (cyc > 1 && !rst) begin
      check(bus_req_o == m_req, "R3 req", int'(bus_req_o), int'(m_req));
      if (m_req) begin
        check(int'(bus_op_o) == m_op, "R3 op", int'(bus_op_o), m_op);
        if (m_op == 1) check(int'(bus_data_o) == m_data, "R4 probe byte", int'(bus_data_o), m_data);
      end
      check(done_o == m_done, "R6 done", int'(done_o), int'(m_done));
      check(timeout_o == m_to, "R8 timeout", int'(timeout_o), int'(m_to));
      check(busy_o == (m_state != 0), "R10 busy", int'(busy_o), int'(m_state != 0));
      if (r2_pending) begin
        check(busy_o && bus_req_o && bus_op_o == 2'd0, "R2 start request",
              int'({busy_o, bus_req_o, bus_op_o}), 'b1100);
        r2_pending = 0;
      end
      if (done_o) n_done++;
      if (timeout_o) n_to++;
    end
    // drive start pulse
    start_i = go;
    if (go && m_state == 0 && !rst) r2_pending = 1;
    go = 0;
    // engine stub with rotating latency
    bus_ack_i = 0;
    bus_nack_i = 0;
    if (bus_req_o && !rst) begin
      if (wcnt >= lat) begin
        bus_ack_i = 1;
        if (bus_op_o == 2'd1 && nacks_left > 0) begin
          bus_nack_i = 1;
          nacks_left--;
        end
        case (bus_op_o)
          2'd0: n_start++;
          2'd1: n_byte++;
          default: n_stop++;
        endcase
        wcnt = 0;
        lat = (lat + 1) % 3;
      end else begin
        wcnt++;
      end
    end
    // advance the model to the state after the coming edge
    fin = m_req && bus_ack_i;
    m_done = 0;
    m_to = 0;
    if (rst) begin
      m_state = 0; m_req = 0; m_tries = 0;
    end else begin
      if (fin) m_req = 0;
      case (m_state)
        0: if (start_i) begin
             m_probe = {dev_addr_i, rw_i};
             m_tries = 0; m_req = 1; m_op = 0; m_state = 1;
           end
        1: if (fin) begin m_req = 1; m_op = 1; m_data = m_probe; m_state = 2; end
        2: if (fin) begin
             m_tries++;
             if (!bus_nack_i) begin
               m_done = 1;
               if (pend_i) m_state = 0;
               else begin m_req = 1; m_op = 2; m_state = 4; end
             end else if (m_tries == MAXT) begin
               m_to = 1; m_req = 1; m_op = 2; m_state = 4;
             end else begin
               m_req = 1; m_op = 2; m_state = 3;
             end
           end
        3: if (fin) begin m_req = 1; m_op = 0; m_state = 1; end
        default: if (fin) m_state = 0;
      endcase
    end
  end

  task automatic run(input int nacks, input bit pend, input bit rw, input int addr,
                     input bit disturb);
    int exp_probes;
    bit exp_to;
    n_start = 0; n_byte = 0; n_stop = 0; n_done = 0; n_to = 0;
    nacks_left = nacks;
    pend_i = pend;
    rw_i = rw;
    dev_addr_i = 7'(addr);
    @(posedge clk);
    go = 1;
    repeat (3) @(posedge clk);
    if (disturb) begin
      repeat (4) @(posedge clk);
      dev_addr_i = ~dev_addr_i;
      rw_i = ~rw_i;
      go = 1;  // R9: must be ignored while busy
    end
    while (busy_o) @(posedge clk);
    repeat (3) @(posedge clk);
    exp_to = (nacks >= MAXT);
    exp_probes = exp_to ? MAXT : nacks + 1;
    check(n_start == exp_probes, disturb ? "R9 start count" : "R5 start count", n_start, exp_probes);
    check(n_byte == exp_probes, "R5 probe count", n_byte, exp_probes);
    check(n_stop == (exp_to ? MAXT : nacks + (pend ? 0 : 1)), "R7 stop count", n_stop,
          exp_to ? MAXT : nacks + (pend ? 0 : 1));
    check(n_done == (exp_to ? 0 : 1), "R6 done count", n_done, exp_to ? 0 : 1);
    check(n_to == (exp_to ? 1 : 0), "R8 timeout count", n_to, exp_to ? 1 : 0);
    check(!bus_req_o && !busy_o, "R7 idle after sequence", int'({bus_req_o, busy_o}), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check(!bus_req_o && !busy_o && !done_o && !timeout_o, "R1 reset",
          int'({bus_req_o, busy_o, done_o, timeout_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_req_o && !busy_o && !done_o && !timeout_o, "R1 after reset",
          int'({bus_req_o, busy_o, done_o, timeout_o}), 0);
    run(0, 0, 0, 'h50, 0);
    run(2, 0, 1, 'h2A, 0);
    run(3, 1, 0, 'h7F, 0);   // success on the last permitted probe, bus kept open
    run(4, 0, 1, 'h01, 0);   // every probe refused: timeout
    run(6, 1, 0, 'h33, 0);   // refusals beyond the limit
    run(1, 0, 1, 'h44, 1);   // restart request and input changes mid-poll
    run(0, 1, 1, 'h00, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule